// File: doc/BRIEF.md
# Cache Line Decay Controller

This block manages leakage for a group of cache lines by turning off lines that have sat unused for too long. A shared prescaler emits a coarse tick every `TICK_LEN` clock cycles. Each line keeps a small saturating idle counter that advances on every tick and is cleared by any access to that line. When the idle count of a valid line reaches its decay threshold, the line is marked invalid and switched to its low-power state. A later access to that line is therefore reported as a miss and powers the line back up.

A line holding modified data is not dropped at once. It raises a writeback request that names the line, and it stays valid and powered until the request is acknowledged. When several lines wait for writeback, the lowest line index is presented first.

In adaptive mode, each line keeps a smoothed inter-access gap and a small access count. Once a line has been accessed at least twice, its threshold is that average gap plus a fixed margin. Lines with less history use the programmed interval.

Top module: `decay_ctrl`

## Requirements
- R1: After reset every line is powered on (`line_off`=0) and invalid (`line_valid`=0), `wb_req` is 0, and all idle counters, gap averages and access counts are zero.
- R2: An access (`acc_valid`=1 with `acc_idx`) makes that line valid and powered on after the clock edge. One cycle after the access, `hit_valid` is 1 and `hit` is 1 exactly when the line was valid and powered on before the access.
- R3: Idle time is counted in ticks of `TICK_LEN` cycles. With threshold T>0, a clean valid line is still valid no earlier than (T-1)·TICK_LEN+1 cycles after its last access. It is invalid and powered off by T·TICK_LEN+1 cycles after that access.
- R4: Any access clears the line's idle count, so a line accessed more often than its threshold never decays.
- R5: In fixed mode a programmed interval of 0 disables decay: valid lines stay valid and powered on indefinitely.
- R6: A dirty line that reaches its threshold raises `wb_req` with `wb_idx` set to its index. It stays valid and powered on until `wb_ack` is sampled high with `wb_req`. The edge that samples the acknowledge makes the line invalid, powered off and clean.
- R7: While more than one line awaits writeback, `wb_idx` presents the lowest pending index. After its acknowledge, the next lowest is presented.
- R8: An access to a line awaiting writeback withdraws its request. The line stays valid and dirty, and its idle count restarts.
- R9: An access to a decayed (powered-off) line reports `hit`=0.
- R10: With `cfg_adapt`=1, a line with two or more recorded accesses uses (smoothed gap + `MARGIN`) ticks as its threshold, saturated at the counter maximum. The first gap is copied as is and later gaps are averaged with the stored value. A line with fewer accesses uses `cfg_interval`.
- R11: With `cfg_adapt`=0, every line uses `cfg_interval`, whatever its history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe for one line |
| acc_idx | input | IDX_W | Index of the accessed line |
| acc_write | input | 1 | Access modifies the line (sets dirty) |
| cfg_interval | input | IDLE_W | Programmed decay threshold in ticks; 0 disables decay |
| cfg_adapt | input | 1 | Enables per-line adaptive thresholds |
| line_valid | output | LINES | Per-line valid flags |
| line_off | output | LINES | Per-line power-off flags |
| hit_valid | output | 1 | Registered marker for the previous cycle's access |
| hit | output | 1 | Previous access found its line valid and powered |
| wb_req | output | 1 | A dirty decaying line awaits writeback |
| wb_idx | output | IDX_W | Line presented for writeback |
| wb_ack | input | 1 | Writeback of the presented line is done |

## Verification
The bench checks both edges of the decay window against the tick phase. A design that counts raw cycles, or that is one tick late, would either still hold the line at the upper bound or drop it before the lower bound. It holds a dirty line past its threshold to check that the line stays valid until acknowledge, and it runs two pending lines at once to catch a design that acknowledges the wrong line or presents the higher index first. It re-accesses a line during a pending writeback, where a faulty design would power the line off anyway. It also trains one line with long gaps next to a fresh line, so that a design ignoring history, or applying it without adaptive mode, decays the wrong one.

// File: rtl/decay_pkg.sv
package decay_pkg;

    // Life cycle of one cache line as seen by the decay logic.
    typedef enum logic [1:0] {
        LS_EMPTY = 2'd0,  // powered, holds no data
        LS_LIVE  = 2'd1,  // powered, valid
        LS_DRAIN = 2'd2,  // valid, dirty, waiting for writeback acknowledge
        LS_SLEEP = 2'd3   // invalid, supply switched off
    } line_state_e;

endpackage

// File: rtl/decay_tick.sv
module decay_tick #(
    parameter int TICK_LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_LEN > 1) ? $clog2(TICK_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_LEN - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/decay_line.sv
module decay_line
    import decay_pkg::*;
#(
    parameter int IDLE_W = 2,
    parameter int MARGIN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              touch,
    input  logic              touch_write,
    input  logic              wb_done,
    input  logic [IDLE_W-1:0] cfg_interval,
    input  logic              cfg_adapt,
    output logic              valid_o,
    output logic              off_o,
    output logic              pend_o
);
    localparam logic [IDLE_W-1:0] CMAX   = {IDLE_W{1'b1}};
    localparam logic [IDLE_W:0]   CMAX_X = {1'b0, {IDLE_W{1'b1}}};
    localparam logic [IDLE_W:0]   MARG_X = (IDLE_W+1)'(MARGIN);

    typedef struct packed {
        line_state_e       st;
        logic              dirty;
        logic [IDLE_W-1:0] idle;
        logic [IDLE_W-1:0] avg;
        logic [1:0]        cnt;
    } line_t;

    line_t s_d, s_q;

    logic [IDLE_W:0]   adapt_sum;
    logic [IDLE_W:0]   gap_sum;
    logic [IDLE_W-1:0] adapt_thr;
    logic [IDLE_W-1:0] thr;
    logic              expire;

    always_comb begin
        s_d       = s_q;
        adapt_sum = {1'b0, s_q.avg} + MARG_X;
        adapt_thr = (adapt_sum > CMAX_X) ? CMAX : adapt_sum[IDLE_W-1:0];
        thr       = (cfg_adapt && (s_q.cnt >= 2'd2)) ? adapt_thr : cfg_interval;
        expire    = (thr != '0) && (s_q.idle >= thr);
        gap_sum   = {1'b0, s_q.avg} + {1'b0, s_q.idle};

        if (tick && (s_q.st != LS_SLEEP) && (s_q.idle != CMAX))
            s_d.idle = s_q.idle + 1'b1;

        case (s_q.st)
            LS_LIVE: begin
                if (expire) begin
                    if (s_q.dirty) begin
                        s_d.st = LS_DRAIN;
                    end else begin
                        s_d.st   = LS_SLEEP;
                        s_d.idle = '0;
                    end
                end
            end
            LS_DRAIN: begin
                if (wb_done) begin
                    s_d.st    = LS_SLEEP;
                    s_d.dirty = 1'b0;
                    s_d.idle  = '0;
                end
            end
            default: ;
        endcase

        // An access overrides decay, acknowledge and tick in the same cycle.
        if (touch) begin
            s_d.st    = LS_LIVE;
            s_d.idle  = '0;
            s_d.dirty = s_q.dirty | touch_write;
            case (s_q.cnt)
                2'd0:    ;
                2'd1:    s_d.avg = s_q.idle;
                default: s_d.avg = gap_sum[IDLE_W:1];
            endcase
            if (s_q.cnt != 2'd3) s_d.cnt = s_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= LS_EMPTY;
            s_q.dirty <= 1'b0;
            s_q.idle  <= '0;
            s_q.avg   <= '0;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = (s_q.st == LS_LIVE) || (s_q.st == LS_DRAIN);
    assign off_o   = (s_q.st == LS_SLEEP);
    assign pend_o  = (s_q.st == LS_DRAIN);
endmodule

// File: rtl/decay_wb_arb.sv
module decay_wb_arb #(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic [LINES-1:0] pend,
    output logic             req,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        req = |pend;
        idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/decay_ctrl.sv
module decay_ctrl #(
    parameter int LINES    = 16,
    parameter int IDLE_W   = 2,
    parameter int TICK_LEN = 256,
    parameter int MARGIN   = 1,
    localparam int IDX_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  logic              acc_write,
    input  logic [IDLE_W-1:0] cfg_interval,
    input  logic              cfg_adapt,
    output logic [LINES-1:0]  line_valid,
    output logic [LINES-1:0]  line_off,
    output logic              hit_valid,
    output logic              hit,
    output logic              wb_req,
    output logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_ack
);
    typedef struct packed {
        logic hv;
        logic h;
    } resp_t;

    resp_t r_d, r_q;
    logic             tick;
    logic [LINES-1:0] pend;

    decay_tick #(.TICK_LEN(TICK_LEN)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = acc_valid && (acc_idx == IDX_W'(g));
        decay_line #(.IDLE_W(IDLE_W), .MARGIN(MARGIN)) u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (tick),
            .touch       (sel),
            .touch_write (acc_write),
            .wb_done     (wb_ack && wb_req && (wb_idx == IDX_W'(g))),
            .cfg_interval(cfg_interval),
            .cfg_adapt   (cfg_adapt),
            .valid_o     (line_valid[g]),
            .off_o       (line_off[g]),
            .pend_o      (pend[g])
        );
    end

    decay_wb_arb #(.LINES(LINES), .IDX_W(IDX_W)) u_arb (
        .pend(pend),
        .req (wb_req),
        .idx (wb_idx)
    );

    always_comb begin
        r_d.hv = acc_valid;
        r_d.h  = acc_valid && line_valid[acc_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hit_valid = r_q.hv;
    assign hit       = r_q.h;
endmodule

// File: rtl/decay_ctrl_chk.sv
module decay_ctrl_chk #(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic [IDX_W-1:0] acc_idx,
    input logic [LINES-1:0] line_valid,
    input logic [LINES-1:0] line_off,
    input logic             hit_valid,
    input logic             hit,
    input logic             wb_req,
    input logic [IDX_W-1:0] wb_idx,
    input logic             wb_ack
);
    assert_access_wakes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (line_valid[$past(acc_idx)] && !line_off[$past(acc_idx)]));

    assert_sleep_is_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && line_off[acc_idx]) |=> (hit_valid && !hit));

    assert_pending_line_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (line_valid[wb_idx] && !line_off[wb_idx]));

    assert_request_persists_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack && !acc_valid) |=> wb_req);

    assert_ack_powers_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_ack && !(acc_valid && acc_idx == wb_idx)) |=> line_off[$past(wb_idx)]);
endmodule

bind decay_ctrl decay_ctrl_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_idx   (acc_idx),
    .line_valid(line_valid),
    .line_off  (line_off),
    .hit_valid (hit_valid),
    .hit       (hit),
    .wb_req    (wb_req),
    .wb_idx    (wb_idx),
    .wb_ack    (wb_ack)
);

// File: tb/sim_decay_ctrl.sv
module sim_decay_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [1:0]    acc_idx = '0;
    logic          acc_write = 1'b0;
    logic [IW-1:0] cfg_interval = 4'd2;
    logic          cfg_adapt = 1'b0;
    logic [NL-1:0] line_valid, line_off;
    logic          hit_valid, hit, wb_req, wb_ack = 1'b0;
    logic [1:0]    wb_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit h;

    always #(CLK_PERIOD/2) clk = ~clk;

    decay_ctrl #(.LINES(NL), .IDLE_W(IW), .TICK_LEN(4), .MARGIN(2)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
        .acc_write(acc_write), .cfg_interval(cfg_interval), .cfg_adapt(cfg_adapt),
        .line_valid(line_valid), .line_off(line_off), .hit_valid(hit_valid),
        .hit(hit), .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack)
    );

    // op: 0 wait only, 1 read, 2 write; ewb: bit1 = check, bit0 = expected wb_req
    typedef struct packed {
        logic [1:0] op;
        logic [1:0] idx;
        logic [7:0] wt;
        logic [3:0] ev;
        logic [3:0] eo;
        logic [1:0] ewb;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'd1, 2'd0, 8'd2, 4'b0001, 4'b0000, 2'b10},
        '{2'd2, 2'd1, 8'd2, 4'b0011, 4'b0000, 2'b10},
        '{2'd0, 2'd0, 8'd4, 4'b0010, 4'b0001, 2'b00},
        '{2'd0, 2'd0, 8'd4, 4'b0010, 4'b0001, 2'b11},
        '{2'd1, 2'd0, 8'd2, 4'b0011, 4'b0000, 2'b11}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_e(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        acc_valid = 1'b0;
        wb_ack = 1'b0;
        wait_e(3);
        rst_n = 1'b1;
    endtask

    task automatic access(input int idx, input bit wr, output bit hv_hit);
        acc_valid = 1'b1;
        acc_idx   = 2'(idx);
        acc_write = wr;
        @(posedge clk);
        #2;
        acc_valid = 1'b0;
        acc_write = 1'b0;
        chk("R2 hit_valid", int'(hit_valid), 1);
        hv_hit = hit;
    endtask

    task automatic ack();
        wb_ack = 1'b1;
        @(posedge clk);
        #2;
        wb_ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 valid", int'(line_valid), 0);
        chk("R1 off", int'(line_off), 0);
        chk("R1 wb_req", int'(wb_req), 0);

        // Vector walk: R3 decay window, R6 dirty line held, R2 wake
        foreach (VECS[k]) begin
            if (VECS[k].op != 2'd0) access(int'(VECS[k].idx), VECS[k].op == 2'd2, h);
            wait_e(int'(VECS[k].wt));
            chk("R3 vec valid", int'(line_valid), int'(VECS[k].ev));
            chk("R3 vec off", int'(line_off), int'(VECS[k].eo));
            if (VECS[k].ewb[1]) chk("R6 vec wb_req", int'(wb_req), int'(VECS[k].ewb[0]));
        end
        chk("R6 wb_idx", int'(wb_idx), 1);

        // R1: reset clears a pending writeback and sleeping lines
        do_reset();
        chk("R1 valid after rerun", int'(line_valid), 0);
        chk("R1 wb_req after rerun", int'(wb_req), 0);

        // R2 / R9: miss on empty, hit on valid, miss after decay
        access(2, 1'b0, h);
        chk("R2 miss on empty", int'(h), 0);
        access(2, 1'b0, h);
        chk("R2 hit on valid", int'(h), 1);
        wait_e(10);
        chk("R3 clean line off", int'(line_off[2]), 1);
        access(2, 1'b0, h);
        chk("R9 miss after decay", int'(h), 0);
        chk("R2 woken", int'(line_off[2]), 0);

        // R4: repeated accesses keep a line alive
        do_reset();
        access(0, 1'b0, h);
        for (int i = 0; i < 6; i++) begin
            wait_e(4);
            access(0, 1'b0, h);
        end
        wait_e(4);
        chk("R4 still valid", int'(line_valid[0]), 1);
        chk("R4 not off", int'(line_off[0]), 0);

        // R5: interval 0 never decays
        cfg_interval = 4'd0;
        access(1, 1'b0, h);
        wait_e(40);
        chk("R5 valid", int'(line_valid[1]), 1);
        chk("R5 off", int'(line_off[1]), 0);
        cfg_interval = 4'd2;

        // R6 / R7: two dirty lines, lowest first
        do_reset();
        access(1, 1'b1, h);
        access(2, 1'b1, h);
        wait_e(12);
        chk("R6 wb_req", int'(wb_req), 1);
        chk("R7 lowest first", int'(wb_idx), 1);
        chk("R6 held valid", int'(line_valid), 6);
        ack();
        chk("R6 acked line off", int'(line_off[1]), 1);
        chk("R6 acked line invalid", int'(line_valid[1]), 0);
        chk("R7 next index", int'(wb_idx), 2);
        ack();
        chk("R6 wb_req clear", int'(wb_req), 0);
        chk("R6 off mask", int'(line_off), 6);

        // R8: access withdraws a pending writeback
        access(3, 1'b1, h);
        wait_e(10);
        chk("R8 pending", int'(wb_req), 1);
        access(3, 1'b0, h);
        chk("R8 hit on pending", int'(h), 1);
        chk("R8 withdrawn", int'(wb_req), 0);
        chk("R8 valid", int'(line_valid[3]), 1);
        wait_e(10);
        chk("R8 still dirty", int'(wb_req), 1);

        // R10: trained line uses its gap, fresh line uses interval
        do_reset();
        cfg_interval = 4'd15;
        cfg_adapt = 1'b1;
        access(0, 1'b0, h);
        wait_e(19);
        access(0, 1'b0, h);
        wait_e(19);
        access(0, 1'b0, h);
        cfg_interval = 4'd2;
        access(1, 1'b0, h);
        wait_e(11);
        chk("R10 trained line kept", int'(line_valid[0]), 1);
        chk("R10 fresh line off", int'(line_off[1]), 1);
        wait_e(20);
        chk("R10 trained line decays", int'(line_off[0]), 1);

        // R11: adaptive off, history ignored
        cfg_adapt = 1'b0;
        access(0, 1'b0, h);
        access(1, 1'b0, h);
        wait_e(10);
        chk("R11 both off", int'(line_off[1:0]), 3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule